// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Mode

This block moves a stream of words from one clock domain to another. The writer pushes a word on any write-clock edge where it asserts its write enable. The reader pulls words in its own clock domain. The read and write pointers are Gray-coded and pass through two-flop synchronizers. Each side therefore sees the other's progress two of its own clock edges late. Each side judges occupancy from its own pointer and the synchronized copy of the other pointer.

A mode input is captured while the shared reset is held low. In standard mode, every word, including the first, is fetched with an explicit read, and the two status outputs report empty and full. In fall-through mode, the oldest word is moved to the output register without a request, and the status outputs report output-valid and input-space. The fall-through output register adds one word of capacity.

A half-full indication can only be raised by write-side logic and only be lowered by read-side logic. It is formed from one toggle flop in each domain.

Top module: `dcfifo_ff`

## Requirements
- R1: `fwft_sel` is captured on every clock edge while `rst_n` is low: 0 selects standard mode and 1 selects fall-through mode. Changes on `fwft_sel` after reset has been released have no effect.
- R2: In standard mode, `rd_status` is 1 when the FIFO is empty and `wr_status` is 1 when it holds `2**ADDR_W` words. A word reaches `dout` only on an rclk edge with `ren` high, and it is visible just after that edge. Words come out in write order.
- R3: In fall-through mode, `rd_status` is 1 while `dout` holds a valid word and `wr_status` is 1 while a write would be accepted. The first word written into an empty FIFO is on `dout`, with `rd_status` high, after the third rclk edge that follows the write edge, and no `ren` is needed for this. Capacity is `2**ADDR_W + 1` words.
- R4: With `ren` low, `dout` keeps its value: always in standard mode, and in fall-through mode while `rd_status` is high.
- R5: A write while full and a read while empty are ignored in both modes. They change neither the stored data nor the word count.
- R6: In standard mode, after a write into an empty FIFO, `rd_status` is still 1 after the first following rclk edge and is 0 after the second. After a read from a full FIFO, `wr_status` is still 1 after the first following wclk edge and is 0 after the second.
- R7: In fall-through mode, a read with `rd_status` high while no further word is stored clears `rd_status` on that same rclk edge. If another word is stored, it is loaded onto `dout` on that edge and `rd_status` stays 1.
- R8: Once both clocks have run for six cycles with no traffic, `half_full` is 1 exactly when more than `2**ADDR_W / 2` words are held in the storage array. In fall-through mode the output register is not counted. `half_full` rises only on a wclk edge and falls only on an rclk edge.
- R9: Under concurrent writes and reads with arbitrary gaps, every accepted word is delivered exactly once and in order in both modes. Each pointer changes by at most one bit per clock edge of its domain.
- R10: Straight after reset, `dout` is 0 and `half_full` is 0. In standard mode `rd_status` is 1 and `wr_status` is 0. In fall-through mode `rd_status` is 0 and `wr_status` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low master reset, sampled synchronously in both domains |
| fwft_sel | input | 1 | Mode select, captured during reset (1 = fall-through) |
| wen | input | 1 | Write request for the current wclk edge |
| din | input | DATA_W | Write data |
| wr_status | output | 1 | Full (standard mode) or input-space (fall-through mode) |
| ren | input | 1 | Read request for the current rclk edge |
| dout | output | DATA_W | Registered read data |
| rd_status | output | 1 | Empty (standard mode) or output-valid (fall-through mode) |
| half_full | output | 1 | More than half the storage array is occupied |

## Verification
A write pointer that moves while the FIFO is full, or a read pointer that moves while it is empty, shows up at the ports as a corrupted or duplicated word at the scoreboard. It appears as soon as the following words are drained. A wrong synchronizer depth or a wrongly latched mode shows up within three edges of the first write or read: a status output changes one edge early or late, or takes the wrong polarity. A fall-through output register that loses its valid state either presents stale data or drops `rd_status` before the last word has been taken. A half-full toggle that is out of step leaves `half_full` inverted once the traffic settles.

// File: rtl/dcf_pkg.sv
// Shared definitions for the dual-clock FIFO: mode encoding and Gray helpers.
// Assumes pointer widths never exceed 32 bits.
package dcf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dcf_mode_e;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary (prefix XOR from the top bit).
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync2.sv
// Two-flop synchronizer for a bus whose value changes in at most one bit per
// source edge (Gray pointer or toggle). Reset clears both stages.
module dcf_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Sample the foreign-domain value and pass it through a second stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/dcf_mem.sv
// Storage array: one synchronous write port on wclk and one combinational
// read port. The read side only addresses words that it knows were written.
module dcf_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-side control. It keeps the binary and Gray write pointers, derives
// full from the synchronized read pointer, and owns the set toggle of the
// half-full flag. Assumes rgray_s is already synchronized into wclk.
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic [ADDR_W:0]   rgray_s,
    input  logic              hf_clr_tog_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full,
    output logic              wr_status,
    output dcf_mode_e         mode_w,
    output logic              hf_set_tog
);

    localparam int             PW        = ADDR_W + 1;
    localparam int             DEPTH     = 1 << ADDR_W;
    localparam logic [PW-1:0]  DEPTH_CNT = PW'(DEPTH);
    localparam logic [PW-1:0]  HALF_CNT  = PW'(DEPTH / 2);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] fill_w;

    assign rbin_s   = PW'(from_gray(32'(rgray_s)));
    assign fill_w   = wbin - rbin_s;
    assign full     = (fill_w == DEPTH_CNT);
    assign we       = wen & ~full;
    assign wbin_nxt = wbin + PW'(1);
    assign waddr    = wbin[ADDR_W-1:0];
    assign wr_status = (mode_w == MODE_FWFT) ? ~full : full;

    // Capture the operating mode while reset is held.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            mode_w <= dcf_mode_e'(fwft_sel);
        end
    end

    // Advance the write pointer on every accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nxt;
            wgray <= PW'(to_gray(32'(wbin_nxt)));
        end
    end

    // Raise half-full by toggling when the flag looks low and the count is high.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            hf_set_tog <= 1'b0;
        end else if ((fill_w > HALF_CNT) && (hf_set_tog == hf_clr_tog_s)) begin
            hf_set_tog <= ~hf_set_tog;
        end
    end

endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-side control. It keeps the read pointers, derives the storage-empty
// condition from the synchronized write pointer, and runs the output register
// in standard or fall-through style. It owns the clear toggle of half-full.
// Assumes wgray_s is already synchronized into rclk.
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              ren,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              hf_set_tog_s,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              ram_empty,
    output logic [DATA_W-1:0] dout,
    output logic              rd_status,
    output dcf_mode_e         mode_r,
    output logic              hf_clr_tog
);

    localparam int            PW       = ADDR_W + 1;
    localparam int            DEPTH    = 1 << ADDR_W;
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] fill_r;
    logic          out_vld;
    logic          pop;

    assign wbin_s    = PW'(from_gray(32'(wgray_s)));
    assign fill_r    = wbin_s - rbin;
    assign ram_empty = (rgray == wgray_s);
    assign raddr     = rbin[ADDR_W-1:0];
    assign rbin_nxt  = rbin + PW'(1);

    // Decide whether the storage array gives up its oldest word this edge.
    always_comb begin
        if (mode_r == MODE_FWFT) begin
            pop = ~ram_empty & (~out_vld | ren);
        end else begin
            pop = ~ram_empty & ren;
        end
    end

    assign rd_status = (mode_r == MODE_FWFT) ? out_vld : ram_empty;

    // Capture the operating mode while reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            mode_r <= dcf_mode_e'(fwft_sel);
        end
    end

    // Advance the read pointer on every word taken from storage.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_nxt;
            rgray <= PW'(to_gray(32'(rbin_nxt)));
        end
    end

    // Load the output register with a popped word; otherwise hold it.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (pop) begin
            dout <= mem_rdata;
        end
    end

    // Track whether the fall-through output register holds an unread word.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else if (pop) begin
            out_vld <= 1'b1;
        end else if (ren) begin
            out_vld <= 1'b0;
        end
    end

    // Lower half-full by toggling when the flag looks high and the count is low.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            hf_clr_tog <= 1'b0;
        end else if ((fill_r <= HALF_CNT) && (hf_set_tog_s != hf_clr_tog)) begin
            hf_clr_tog <= ~hf_clr_tog;
        end
    end

endmodule

// File: rtl/dcfifo_ff.sv
// Dual-clock FIFO top. It ties together the write control, the read control,
// the storage array and the cross-domain synchronizers. The mode is latched
// in each domain during reset. rst_n must be held low for several edges of
// both clocks.
module dcfifo_ff
    import dcf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    output logic              wr_status,
    input  logic              ren,
    output logic [DATA_W-1:0] dout,
    output logic              rd_status,
    output logic              half_full
);

    localparam int PW = ADDR_W + 1;

    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_s;
    logic [PW-1:0]     rgray_s;
    logic [DATA_W-1:0] mem_rdata;
    logic              wr_full;
    logic              ram_empty;
    logic              hf_set_tog;
    logic              hf_clr_tog;
    logic              hf_set_tog_s;
    logic              hf_clr_tog_s;
    dcf_mode_e         mode_w;
    dcf_mode_e         mode_r;

    dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk         (wclk),
        .rst_n        (rst_n),
        .fwft_sel     (fwft_sel),
        .wen          (wen),
        .rgray_s      (rgray_s),
        .hf_clr_tog_s (hf_clr_tog_s),
        .we           (we),
        .waddr        (waddr),
        .wgray        (wgray),
        .full         (wr_full),
        .wr_status    (wr_status),
        .mode_w       (mode_w),
        .hf_set_tog   (hf_set_tog)
    );

    dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rclk         (rclk),
        .rst_n        (rst_n),
        .fwft_sel     (fwft_sel),
        .ren          (ren),
        .wgray_s      (wgray_s),
        .mem_rdata    (mem_rdata),
        .hf_set_tog_s (hf_set_tog_s),
        .raddr        (raddr),
        .rgray        (rgray),
        .ram_empty    (ram_empty),
        .dout         (dout),
        .rd_status    (rd_status),
        .mode_r       (mode_r),
        .hf_clr_tog   (hf_clr_tog)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    dcf_sync2 #(.W(PW)) u_sync_w2r (
        .clk (rclk), .rst_n (rst_n), .d (wgray), .q (wgray_s)
    );

    dcf_sync2 #(.W(PW)) u_sync_r2w (
        .clk (wclk), .rst_n (rst_n), .d (rgray), .q (rgray_s)
    );

    dcf_sync2 #(.W(1)) u_sync_hfset (
        .clk (rclk), .rst_n (rst_n), .d (hf_set_tog), .q (hf_set_tog_s)
    );

    dcf_sync2 #(.W(1)) u_sync_hfclr (
        .clk (wclk), .rst_n (rst_n), .d (hf_clr_tog), .q (hf_clr_tog_s)
    );

    assign half_full = hf_set_tog ^ hf_clr_tog;

endmodule

// File: rtl/dcfifo_ff_chk.sv
// Assertion checker for dcfifo_ff, attached through bind below. It observes
// ports and the pointer, flag and mode nets of the top module.
module dcfifo_ff_chk
    import dcf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              wen,
    input logic              ren,
    input logic              wr_full,
    input logic              ram_empty,
    input dcf_mode_e         mode_w,
    input dcf_mode_e         mode_r,
    input logic [ADDR_W:0]   wgray,
    input logic [ADDR_W:0]   rgray,
    input logic [DATA_W-1:0] dout,
    input logic              rd_status
);

    // R5
    wr_block_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen && wr_full) |=> $stable(wgray));

    // R5
    rd_block_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        ram_empty |=> $stable(rgray));

    // R4
    std_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_r == MODE_STD && !ren) |=> $stable(dout));

    // R4
    fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_r == MODE_FWFT && rd_status && !ren) |=> ($stable(dout) && rd_status));

    // R7
    fwft_last_drop_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_r == MODE_FWFT && rd_status && ren && ram_empty) |=> !rd_status);

    // R1
    mode_w_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $stable(mode_w));

    // R1
    mode_r_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $stable(mode_r));

    // R9
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray)));

    // R9
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $onehot0(rgray ^ $past(rgray)));

endmodule

bind dcfifo_ff dcfifo_ff_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst_n     (rst_n),
    .wen       (wen),
    .ren       (ren),
    .wr_full   (wr_full),
    .ram_empty (ram_empty),
    .mode_w    (mode_w),
    .mode_r    (mode_r),
    .wgray     (wgray),
    .rgray     (rgray),
    .dout      (dout),
    .rd_status (rd_status)
);

// File: tb/dcfifo_ff_bench.sv
// Scoreboard bench for dcfifo_ff: the write driver queues accepted words and
// the read monitor pops and compares them as the design delivers them.
module dcfifo_ff_bench;

    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_sel = 1'b0;
    logic          wen = 1'b0;
    logic          ren = 1'b0;
    logic [DW-1:0] din = '0;
    logic          wr_status;
    logic [DW-1:0] dout;
    logic          rd_status;
    logic          half_full;

    int            checks = 0;
    int            fails = 0;
    bit            mode_b = 1'b0;
    logic [DW-1:0] exp_q[$];

    dcfifo_ff #(.DATA_W(DW), .ADDR_W(AW)) u_dcfifo_ff (
        .wclk      (wclk),
        .rclk      (rclk),
        .rst_n     (rst_n),
        .fwft_sel  (fwft_sel),
        .wen       (wen),
        .din       (din),
        .wr_status (wr_status),
        .ren       (ren),
        .dout      (dout),
        .rd_status (rd_status),
        .half_full (half_full)
    );

    // 50 MHz write clock; read clock of the same rate, phase shifted.
    initial forever #10 wclk = ~wclk;
    initial begin
        #7;
        forever #10 rclk = ~rclk;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_reset(input bit m);
        rst_n = 1'b0;
        fwft_sel = m;
        mode_b = m;
        wen = 1'b0;
        ren = 1'b0;
        exp_q.delete();
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        #1;
    endtask

    // Driver: offer one word; queue it when the status shows space.
    task automatic wr_one(input logic [DW-1:0] d, output bit acc);
        @(negedge wclk);
        wen = 1'b1;
        din = d;
        acc = mode_b ? wr_status : !wr_status;
        if (acc) exp_q.push_back(d);
        @(posedge wclk);
        #1 wen = 1'b0;
    endtask

    task automatic pop_cmp(input string req);
        if (exp_q.size() == 0) begin
            chk(1'b0, req, 32'(dout), 32'hffff_ffff);
        end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(dout == e, req, 32'(dout), 32'(e));
        end
    endtask

    // Monitor: take one word if one is available in the current mode.
    task automatic rd_try(input string req, output bit got);
        got = 1'b0;
        @(negedge rclk);
        if (!mode_b) begin
            if (!rd_status) begin
                ren = 1'b1;
                @(posedge rclk);
                #1 ren = 1'b0;
                got = 1'b1;
                pop_cmp(req);
            end
        end else if (rd_status) begin
            got = 1'b1;
            pop_cmp(req);
            ren = 1'b1;
            @(posedge rclk);
            #1 ren = 1'b0;
        end
    endtask

    task automatic rd_n(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            bit g;
            do rd_try(req, g); while (!g);
        end
    endtask

    task automatic stream(input int n, input string req);
        fork
            begin
                for (int w = 0; w < n; w++) begin
                    bit a;
                    do wr_one(16'(16'h5000 + w * 7), a); while (!a);
                    if (w % 3 == 2) repeat (2) @(posedge wclk);
                end
            end
            begin
                int got_n = 0;
                for (int k = 1; got_n < n; k++) begin
                    bit g;
                    rd_try(req, g);
                    if (g) got_n++;
                    if (k % 5 == 0) @(posedge rclk);
                end
            end
        join
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #4000000;
        fails++;
        $display("FAIL R9 watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit a;
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        chk(rd_status == 1'b1, "R10", 32'(rd_status), 1);
        chk(wr_status == 1'b0, "R10", 32'(wr_status), 0);
        chk(half_full == 1'b0, "R10", 32'(half_full), 0);
        chk(dout == '0, "R10", 32'(dout), 0);

        wr_one(16'hA001, a);
        @(posedge rclk); #1;
        chk(rd_status == 1'b1, "R6 empty after first rclk edge", 32'(rd_status), 1);
        @(posedge rclk); #1;
        chk(rd_status == 1'b0, "R6 empty after second rclk edge", 32'(rd_status), 0);
        repeat (3) @(posedge rclk); #1;
        chk(dout == '0, "R2 no word without read", 32'(dout), 0);
        rd_n(1, "R2");
        chk(rd_status == 1'b1, "R2 empty after last read", 32'(rd_status), 1);

        @(negedge rclk); ren = 1'b1;
        @(posedge rclk); #1 ren = 1'b0;
        chk(dout == 16'hA001, "R5 read on empty", 32'(dout), 32'hA001);
        chk(rd_status == 1'b1, "R5 read on empty", 32'(rd_status), 1);

        for (int i = 0; i < DEPTH; i++) wr_one(16'(16'h1000 + i), a);
        #1;
        chk(wr_status == 1'b1, "R2 full", 32'(wr_status), 1);
        wr_one(16'hDEAD, a);
        chk(wr_status == 1'b1, "R5 write on full", 32'(wr_status), 1);
        repeat (6) @(posedge rclk); #1;
        chk(half_full == 1'b1, "R8 high", 32'(half_full), 1);

        rd_n(1, "R2");
        @(posedge wclk); #1;
        chk(wr_status == 1'b1, "R6 full after first wclk edge", 32'(wr_status), 1);
        @(posedge wclk); #1;
        chk(wr_status == 1'b0, "R6 full after second wclk edge", 32'(wr_status), 0);
        repeat (3) @(posedge rclk); #1;
        chk(dout == 16'h1000, "R4 standard hold", 32'(dout), 32'h1000);

        rd_n(7, "R2");
        repeat (6) @(posedge rclk); #1;
        chk(half_full == 1'b0, "R8 at half", 32'(half_full), 0);
        rd_n(8, "R2");
        #1;
        chk(rd_status == 1'b1, "R5 no extra word", 32'(rd_status), 1);
        chk(exp_q.size() == 0, "R5 queue drained", 32'(exp_q.size()), 0);

        stream(40, "R9 standard");

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        chk(rd_status == 1'b0, "R10 fwft", 32'(rd_status), 0);
        chk(wr_status == 1'b1, "R10 fwft", 32'(wr_status), 1);
        chk(half_full == 1'b0, "R10 fwft", 32'(half_full), 0);
        fwft_sel = 1'b0;
        repeat (3) @(posedge wclk); #1;
        chk(wr_status == 1'b1, "R1 mode held", 32'(wr_status), 1);

        wr_one(16'hB001, a);
        @(posedge rclk); #1;
        chk(rd_status == 1'b0, "R3 edge1", 32'(rd_status), 0);
        @(posedge rclk); #1;
        chk(rd_status == 1'b0, "R3 edge2", 32'(rd_status), 0);
        @(posedge rclk); #1;
        chk(rd_status == 1'b1, "R3 edge3 valid", 32'(rd_status), 1);
        chk(dout == 16'hB001, "R3 edge3 data", 32'(dout), 32'hB001);
        repeat (3) @(posedge rclk); #1;
        chk(dout == 16'hB001 && rd_status, "R4 fwft hold", 32'(dout), 32'hB001);

        wr_one(16'hB002, a);
        repeat (4) @(posedge rclk);
        rd_n(1, "R7");
        chk(rd_status == 1'b1, "R7 next word loaded", 32'(rd_status), 1);
        chk(dout == 16'hB002, "R7 next word loaded", 32'(dout), 32'hB002);
        rd_n(1, "R7");
        chk(rd_status == 1'b0, "R7 drop on last read", 32'(rd_status), 0);
        @(negedge rclk); ren = 1'b1;
        @(posedge rclk); #1 ren = 1'b0;
        chk(dout == 16'hB002 && !rd_status, "R5 fwft read on empty", 32'(dout), 32'hB002);

        wr_one(16'hC000, a);
        repeat (6) @(posedge rclk);
        for (int i = 1; i <= DEPTH; i++) wr_one(16'(16'hC000 + i), a);
        #1;
        chk(wr_status == 1'b0, "R3 capacity", 32'(wr_status), 0);
        chk(exp_q.size() == DEPTH + 1, "R3 capacity", 32'(exp_q.size()), DEPTH + 1);
        wr_one(16'hDEAD, a);
        chk(wr_status == 1'b0, "R5 fwft write on full", 32'(wr_status), 0);
        rd_n(DEPTH + 1, "R3");
        repeat (4) @(posedge rclk); #1;
        chk(rd_status == 1'b0, "R5 fwft no extra word", 32'(rd_status), 0);

        stream(60, "R9 fwft");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule